// File: doc/BRIEF.md
# Dual-Mode Alarm Unit for a Real-Time Clock

This block raises the alarm interrupt for a timekeeper. It works in one of two modes, chosen by a control write. In countdown mode, software loads a count of seconds remaining. The unit subtracts one on each seconds tick and flags the alarm on the tick that brings the count from one to zero. In absolute mode, software loads a target day number and an hour/minute/second value, in the same encoding the timekeeper uses for the current time. The unit flags the alarm when the current time equals that target.

Each alarm sets a sticky pending flag. Software clears the flag by writing 1 to it. Writing a new target, in either mode, also clears the flag. The interrupt output is the pending flag gated by an enable bit. The same signal becomes a wake request while the system is suspended. The time counter itself lives outside the block. It supplies the seconds tick and the current time.

Top module: `rtc_alarm`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `pending`, `irq` and `wake` are 0 and `remain` is 0. The mode resets to countdown (`ctl_mode`=0) and the enable resets to 0.
- R2: A cycle with `cnt_wr`=1 loads `cnt_wdata` into `remain`, visible the next cycle. In countdown mode, each `sec_tick` pulse with `remain` nonzero lowers `remain` by one. A load in the same cycle as a tick takes priority, and the tick is lost.
- R3: In countdown mode, a tick that takes `remain` from 1 to 0 sets `pending` in the next cycle. A count of zero never sets `pending`, however many ticks arrive.
- R4: In absolute mode (`ctl_mode`=1), `pending` sets in the cycle after `now_day`, `now_hour`, `now_min` and `now_sec` all equal the loaded target. A difference in any one field prevents the alarm.
- R5: Once set, `pending` holds until a cycle with `clr_wr`=1 and `clr_data`=1. A clear write with `clr_data`=0 has no effect.
- R6: If an alarm event and a clear write fall in the same cycle, the alarm wins and `pending` is 1 afterwards.
- R7: A `cnt_wr` or `abs_wr` clears `pending` in the next cycle. It also discards any alarm event of the same cycle.
- R8: `irq` equals `pending` AND the enable bit. `ctl_wr` sets `ctl_mode` and `ctl_en` together.
- R9: `wake` equals `irq` while `suspend` is 1, and is 0 otherwise.
- R10: An absolute target fires at most once per `abs_wr`. Seconds ticks in absolute mode leave `remain` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| now_day | input | DAY_W | Current day number |
| now_hour | input | 5 | Current hour |
| now_min | input | 6 | Current minute |
| now_sec | input | 6 | Current second |
| ctl_wr | input | 1 | Write strobe for mode and enable |
| ctl_mode | input | 1 | 0 selects countdown, 1 selects absolute |
| ctl_en | input | 1 | Interrupt enable |
| cnt_wr | input | 1 | Load strobe for the countdown |
| cnt_wdata | input | CNT_W | Seconds remaining |
| abs_wr | input | 1 | Load strobe for the absolute target |
| abs_day | input | DAY_W | Target day number |
| abs_hour | input | 5 | Target hour |
| abs_min | input | 6 | Target minute |
| abs_sec | input | 6 | Target second |
| clr_wr | input | 1 | Write strobe for the pending flag |
| clr_data | input | 1 | 1 clears the pending flag |
| suspend | input | 1 | System is suspended |
| remain | output | CNT_W | Countdown value now held |
| pending | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Wake request during suspend |

## Verification
Three things can fall in one cycle: an alarm event, a clear write and a target reload. Each collision needs its own pairing. The bench drives a clear write on exactly the tick that brings the count to zero, and expects `pending` set. It drives a reload on the tick where `remain` is 1, and expects `pending` low with `remain` holding the new value. A random phase then mixes small counts, ticks, clears, reloads and mode changes. A behavioural model judges every cycle of it against the priority order reload, then set, then clear.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;

    typedef enum logic {
        ALARM_COUNT = 1'b0,
        ALARM_ABS   = 1'b1
    } alarm_mode_e;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic [SEC_W-1:0]  second;
    } hms_t;

    typedef struct packed {
        alarm_mode_e mode;
        logic        en;
    } alarm_ctl_t;

    function automatic logic hms_same(input hms_t a, input hms_t b);
        return (a.hour == b.hour) && (a.minute == b.minute) && (a.second == b.second);
    endfunction

endpackage

// File: rtl/rtc_alarm_countdown.sv
module rtc_alarm_countdown
    import rtc_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] count_q;
    logic             nonzero;

    assign nonzero = (count_q != ZERO);
    // Event only on the final second; a zero count stays silent.
    assign hit     = tick_en && (count_q == ONE);
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= ZERO;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick_en && nonzero) begin
            count_q <= count_q - ONE;
        end
    end

endmodule

// File: rtl/rtc_alarm_abs_cmp.sv
module rtc_alarm_abs_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DAY_W-1:0] load_day,
    input  hms_t             load_hms,
    input  logic             cmp_en,
    input  logic [DAY_W-1:0] now_day,
    input  hms_t             now_hms,
    output logic             hit
);
    logic [DAY_W-1:0] tgt_day_q;
    hms_t             tgt_hms_q;
    logic             armed_q;
    logic             same_time;

    assign same_time = (now_day == tgt_day_q) && hms_same(now_hms, tgt_hms_q);
    assign hit       = armed_q && cmp_en && same_time;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_day_q <= '0;
            tgt_hms_q <= '0;
            armed_q   <= 1'b0;
        end else if (load) begin
            tgt_day_q <= load_day;
            tgt_hms_q <= load_hms;
            armed_q   <= 1'b1;
        end else if (hit) begin
            // One shot per loaded target.
            armed_q   <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic event_in,
    input  logic clear,
    input  logic enable,
    input  logic suspend,
    output logic pending,
    output logic irq,
    output logic wake
);
    logic pend_q;

    // Priority: reload, then new event, then software clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (reload) begin
            pend_q <= 1'b0;
        end else if (event_in) begin
            pend_q <= 1'b1;
        end else if (clear) begin
            pend_q <= 1'b0;
        end
    end

    assign pending = pend_q;
    assign irq     = pend_q && enable;
    assign wake    = irq && suspend;

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_alarm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DAY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [DAY_W-1:0]  now_day,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic              ctl_wr,
    input  logic              ctl_mode,
    input  logic              ctl_en,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              abs_wr,
    input  logic [DAY_W-1:0]  abs_day,
    input  logic [HOUR_W-1:0] abs_hour,
    input  logic [MIN_W-1:0]  abs_min,
    input  logic [SEC_W-1:0]  abs_sec,
    input  logic              clr_wr,
    input  logic              clr_data,
    input  logic              suspend,
    output logic [CNT_W-1:0]  remain,
    output logic              pending,
    output logic              irq,
    output logic              wake
);
    alarm_ctl_t ctl_q;
    logic       mode_is_abs;
    logic       cd_hit;
    logic       abs_hit;
    logic       any_reload;
    hms_t       now_hms;
    hms_t       tgt_hms;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{mode: ALARM_COUNT, en: 1'b0};
        end else if (ctl_wr) begin
            ctl_q <= '{mode: alarm_mode_e'(ctl_mode), en: ctl_en};
        end
    end

    assign mode_is_abs = (ctl_q.mode == ALARM_ABS);
    assign any_reload  = cnt_wr || abs_wr;
    assign now_hms     = '{hour: now_hour, minute: now_min, second: now_sec};
    assign tgt_hms     = '{hour: abs_hour, minute: abs_min, second: abs_sec};

    rtc_alarm_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .tick_en  (sec_tick && !mode_is_abs),
        .count    (remain),
        .hit      (cd_hit)
    );

    rtc_alarm_abs_cmp #(.DAY_W(DAY_W)) u_abs (
        .clk      (clk),
        .rst      (rst),
        .load     (abs_wr),
        .load_day (abs_day),
        .load_hms (tgt_hms),
        .cmp_en   (mode_is_abs),
        .now_day  (now_day),
        .now_hms  (now_hms),
        .hit      (abs_hit)
    );

    rtc_alarm_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .reload   (any_reload),
        .event_in (cd_hit || abs_hit),
        .clear    (clr_wr && clr_data),
        .enable   (ctl_q.en),
        .suspend  (suspend),
        .pending  (pending),
        .irq      (irq),
        .wake     (wake)
    );

endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_tick,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             abs_wr,
    input logic             clr_wr,
    input logic             clr_data,
    input logic             mode_is_abs,
    input logic [CNT_W-1:0] remain,
    input logic             pending
);
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> remain == $past(cnt_wdata));

    assert_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !mode_is_abs && !cnt_wr && remain != '0)
        |=> remain == $past(remain) - CNT_W'(1));

    assert_fire_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !mode_is_abs && remain == CNT_W'(1) && !cnt_wr && !abs_wr)
        |=> pending);

    assert_zero_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_is_abs && remain == '0 && !pending) |=> !pending);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (pending && !clr_wr && !cnt_wr && !abs_wr) |=> pending);

    assert_fall_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past((clr_wr && clr_data) || cnt_wr || abs_wr));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr || abs_wr) |=> !pending);

    assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_is_abs && !cnt_wr) |=> $stable(remain));

endmodule

bind rtc_alarm rtc_alarm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sec_tick    (sec_tick),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (cnt_wdata),
    .abs_wr      (abs_wr),
    .clr_wr      (clr_wr),
    .clr_data    (clr_data),
    .mode_is_abs (mode_is_abs),
    .remain      (remain),
    .pending     (pending)
);

// File: tb/sim_rtc_alarm.sv
module sim_rtc_alarm;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 0;
    logic [15:0] now_day = 0;
    logic [4:0]  now_hour = 0;
    logic [5:0]  now_min = 0, now_sec = 0;
    logic        ctl_wr = 0, ctl_mode = 0, ctl_en = 0;
    logic        cnt_wr = 0;
    logic [31:0] cnt_wdata = 0;
    logic        abs_wr = 0;
    logic [15:0] abs_day = 0;
    logic [4:0]  abs_hour = 0;
    logic [5:0]  abs_min = 0, abs_sec = 0;
    logic        clr_wr = 0, clr_data = 0, suspend = 0;
    logic [31:0] remain;
    logic        pending, irq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rtc_alarm u0 (.*);

    // Behavioural reference model
    logic [31:0] m_rem = 0;
    bit m_pend = 0, m_mode = 0, m_en = 0, m_armed = 0;
    logic [15:0] m_tday = 0;
    logic [16:0] m_thms = 0;

    always @(posedge clk) begin
        bit cd_ev, ab_ev;
        if (rst) begin
            m_rem = 0; m_pend = 0; m_mode = 0; m_en = 0; m_armed = 0;
            m_tday = 0; m_thms = 0;
        end else begin
            cd_ev = sec_tick && !m_mode && m_rem == 1;
            ab_ev = m_armed && m_mode && now_day == m_tday &&
                    {now_hour, now_min, now_sec} == m_thms;
            if (cnt_wr || abs_wr) m_pend = 0;
            else if (cd_ev || ab_ev) m_pend = 1;
            else if (clr_wr && clr_data) m_pend = 0;
            if (cnt_wr) m_rem = cnt_wdata;
            else if (sec_tick && !m_mode && m_rem != 0) m_rem = m_rem - 1;
            if (abs_wr) begin
                m_armed = 1; m_tday = abs_day; m_thms = {abs_hour, abs_min, abs_sec};
            end else if (ab_ev) m_armed = 0;
            if (ctl_wr) begin m_mode = ctl_mode; m_en = ctl_en; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 remain", remain, m_rem);
            chk("R5 pending", {31'b0, pending}, {31'b0, m_pend});
            chk("R8 irq", {31'b0, irq}, {31'b0, m_pend && m_en});
            chk("R9 wake", {31'b0, wake}, {31'b0, m_pend && m_en && suspend});
        end
    end

    task automatic cyc();
        @(negedge clk); #2;
        sec_tick = 0; ctl_wr = 0; cnt_wr = 0; abs_wr = 0; clr_wr = 0; clr_data = 0;
    endtask

    task automatic set_ctl(input bit mode, input bit en);
        ctl_wr = 1; ctl_mode = mode; ctl_en = en; cyc();
    endtask

    task automatic load(input logic [31:0] v);
        cnt_wr = 1; cnt_wdata = v; cyc();
    endtask

    task automatic tick();
        sec_tick = 1; cyc();
    endtask

    task automatic clear(input bit d);
        clr_wr = 1; clr_data = d; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pending in reset", {31'b0, pending}, 0);
        chk("R1 remain in reset", remain, 0);
        #2 rst = 0;
        cyc();
        chk("R1 irq after reset", {31'b0, irq}, 0);
        chk("R1 wake after reset", {31'b0, wake}, 0);

        set_ctl(0, 1);
        load(0);
        repeat (3) tick();
        chk("R3 zero count silent", {31'b0, pending}, 0);

        load(3);
        tick(); cyc(); tick(); tick();
        chk("R3 fires at zero", {31'b0, pending}, 1);
        chk("R8 irq enabled", {31'b0, irq}, 1);
        suspend = 1; cyc();
        chk("R9 wake in suspend", {31'b0, wake}, 1);
        suspend = 0;

        clear(0);
        chk("R5 clear with 0 ignored", {31'b0, pending}, 1);
        cyc(); cyc();
        chk("R5 sticky", {31'b0, pending}, 1);
        clear(1);
        chk("R5 cleared", {31'b0, pending}, 0);

        load(2);
        tick();
        sec_tick = 1; clr_wr = 1; clr_data = 1; cyc();
        chk("R6 set beats clear", {31'b0, pending}, 1);

        sec_tick = 1; cnt_wr = 1; cnt_wdata = 5; cyc();
        chk("R7 reload clears", {31'b0, pending}, 0);
        chk("R2 load wins over tick", remain, 5);

        load(1);
        sec_tick = 1; cnt_wr = 1; cnt_wdata = 7; cyc();
        chk("R7 event discarded", {31'b0, pending}, 0);
        chk("R7 new value held", remain, 7);

        set_ctl(0, 0);
        load(1); tick();
        chk("R8 pending when disabled", {31'b0, pending}, 1);
        chk("R8 irq masked", {31'b0, irq}, 0);
        clear(1);

        set_ctl(1, 1);
        load(9);
        repeat (2) tick();
        chk("R10 no decrement in absolute", remain, 9);
        abs_wr = 1; abs_day = 16'd40; abs_hour = 5'd10; abs_min = 6'd20; abs_sec = 6'd30; cyc();
        now_day = 16'd40; now_hour = 5'd10; now_min = 6'd20; now_sec = 6'd29; cyc(); cyc();
        chk("R4 second differs", {31'b0, pending}, 0);
        now_day = 16'd41; now_sec = 6'd30; cyc(); cyc();
        chk("R4 day differs", {31'b0, pending}, 0);
        now_day = 16'd40; cyc();
        chk("R4 exact match", {31'b0, pending}, 1);
        clear(1); cyc(); cyc();
        chk("R10 fires once", {31'b0, pending}, 0);

        // Mixed random phase
        for (int i = 0; i < 400; i++) begin
            sec_tick = ($urandom_range(0, 2) == 0);
            cnt_wr   = ($urandom_range(0, 9) == 0);
            cnt_wdata = $urandom_range(0, 4);
            clr_wr   = ($urandom_range(0, 5) == 0);
            clr_data = $urandom_range(0, 1) == 1;
            abs_wr   = ($urandom_range(0, 19) == 0);
            abs_sec  = 6'($urandom_range(0, 3));
            now_sec  = 6'($urandom_range(0, 3));
            ctl_wr   = ($urandom_range(0, 29) == 0);
            ctl_mode = $urandom_range(0, 1) == 1;
            ctl_en   = $urandom_range(0, 3) != 0;
            suspend  = $urandom_range(0, 1) == 1;
            cyc();
        end
        cyc();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule